// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns one 32-bit instruction word into the control and operand-select signals for a single-issue integer datapath. It is purely combinational. Each instruction uses one of three layouts: register, immediate or jump. The block pulls out the source register numbers, the shift amount and the immediate. It extends the immediate to the datapath width and picks the destination register that suits the layout. It also produces an ALU operation code and one-bit strobes for register write-back, operand source, memory access, conditional branches and jumps.

The supported set is:
- register-form operations: add, sub, and, or, xor, nor, slt, sltu, sll, srl and jr;
- immediate operations: addi, slti, sltiu, andi and ori;
- word load and word store;
- branch on equal and branch on not-equal;
- absolute jump.

Any other opcode, or any other function code under the register-form opcode, raises an illegal flag. An illegal word keeps every strobe that could change architectural state or control flow inactive. The ALU, register file, memory and PC update logic sit outside this block.

Top module: `instr_ctrl_decode`

## Requirements
- R1: `src_a_idx` equals instr[25:21], `src_b_idx` equals instr[20:16] and `shamt_o` equals instr[10:6], for every instruction word.
- R2: With opcode 000000, the function codes below each set `alu_op` to the listed code, with `reg_we`=1, `dst_sel_rd`=1, `dst_idx`=instr[15:11] and `alu_src_imm`=0:
  - 100000 gives ADD=0;
  - 100010 gives SUB=1;
  - 100100 gives AND=2;
  - 100101 gives OR=3;
  - 100110 gives XOR=4;
  - 100111 gives NOR=5;
  - 101010 gives SLT=6;
  - 101011 gives SLTU=7;
  - 000000 gives SLL=8;
  - 000010 gives SRL=9.
- R3: Opcode 000000 with function 001000 (jump-register) sets `jmp_reg`=1 and `reg_we`=0, with no memory or branch strobe.
- R4: The sign-extending immediate forms set `alu_src_imm`=1, `reg_we`=1, `dst_sel_rd`=0 and `dst_idx`=instr[20:16]. Their `imm_ext` is instr[15:0] with bit 15 copied into all upper bits. The opcodes and ALU codes are:
  - 001000 (addi) gives ADD;
  - 001010 (slti) gives SLT;
  - 001011 (sltiu) gives SLTU.
- R5: Opcode 001100 (andi) gives AND and opcode 001101 (ori) gives OR. Both behave as in R4, except that `imm_ext` has zeros above bit 15.
- R6: Opcode 100011 (load word) sets `mem_rd`=1, `reg_we`=1, `alu_src_imm`=1, ADD, `dst_idx`=instr[20:16] and a sign-extended `imm_ext`.
- R7: Opcode 101011 (store word) sets `mem_wr`=1, `reg_we`=0, `alu_src_imm`=1, ADD and a sign-extended `imm_ext`.
- R8: Opcode 000100 sets `br_eq`=1 and opcode 000101 sets `br_ne`=1. Both use SUB with `alu_src_imm`=0 and `reg_we`=0.
- R9: Opcode 000010 sets `jmp`=1 and `reg_we`=0, with no memory or branch strobe.
- R10: Any opcode outside the list above, or opcode 000000 with an unlisted function code, sets `illegal`=1. It also forces these outputs low: `reg_we`, `dst_sel_rd`, `alu_src_imm`, `mem_rd`, `mem_wr`, `br_eq`, `br_ne`, `jmp` and `jmp_reg`. `alu_op` is ADD in that case.
- R11: At most one of `mem_rd`, `mem_wr`, `br_eq`, `br_ne`, `jmp` and `jmp_reg` is high for any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| src_a_idx | output | 5 | First source register number |
| src_b_idx | output | 5 | Second source register number |
| dst_idx | output | 5 | Selected destination register number |
| shamt_o | output | 5 | Shift amount field |
| imm_ext | output | XLEN | Extended immediate |
| alu_op | output | 4 | ALU operation code |
| reg_we | output | 1 | Register write-back enable |
| dst_sel_rd | output | 1 | Destination taken from the register-form rd field |
| alu_src_imm | output | 1 | Second ALU operand is the immediate |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| br_eq | output | 1 | Branch when operands are equal |
| br_ne | output | 1 | Branch when operands differ |
| jmp | output | 1 | Absolute jump |
| jmp_reg | output | 1 | Jump to register address |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The decoder holds no state, so any fault appears at the ports in the same evaluation as the word that exposes it. A wrong entry in the opcode or function table shows up as:
- a wrong ALU code, or a strobe raised where it should be low;
- a write-back that is enabled where it must be suppressed, for example on a store, a branch or an illegal word.

A wrong extension choice shows up only when immediate bit 15 is set, so random words and directed negative and all-ones immediates both target that bit. A wrong destination mux shows up only when the rd and rt fields differ.

// File: rtl/instr_ctrl_decode.sv
module instr_ctrl_decode #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output logic [4:0]      src_a_idx,
  output logic [4:0]      src_b_idx,
  output logic [4:0]      dst_idx,
  output logic [4:0]      shamt_o,
  output logic [XLEN-1:0] imm_ext,
  output logic [3:0]      alu_op,
  output logic            reg_we,
  output logic            dst_sel_rd,
  output logic            alu_src_imm,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            br_eq,
  output logic            br_ne,
  output logic            jmp,
  output logic            jmp_reg,
  output logic            illegal
);

  localparam int IMMW = 16;
  localparam int EXTW = XLEN - IMMW;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_SLTI  = 6'b001010;
  localparam logic [5:0] OP_SLTIU = 6'b001011;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_SLL  = 6'b000000;
  localparam logic [5:0] FN_SRL  = 6'b000010;
  localparam logic [5:0] FN_JR   = 6'b001000;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;
  localparam logic [5:0] FN_SLT  = 6'b101010;
  localparam logic [5:0] FN_SLTU = 6'b101011;

  localparam logic [3:0] A_ADD  = 4'd0;
  localparam logic [3:0] A_SUB  = 4'd1;
  localparam logic [3:0] A_AND  = 4'd2;
  localparam logic [3:0] A_OR   = 4'd3;
  localparam logic [3:0] A_XOR  = 4'd4;
  localparam logic [3:0] A_NOR  = 4'd5;
  localparam logic [3:0] A_SLT  = 4'd6;
  localparam logic [3:0] A_SLTU = 4'd7;
  localparam logic [3:0] A_SLL  = 4'd8;
  localparam logic [3:0] A_SRL  = 4'd9;

  logic [5:0]      opc;
  logic [5:0]      fn;
  logic [IMMW-1:0] imm;
  logic            zext;

  assign opc       = instr_i[31:26];
  assign fn        = instr_i[5:0];
  assign imm       = instr_i[15:0];
  assign src_a_idx = instr_i[25:21];
  assign src_b_idx = instr_i[20:16];
  assign shamt_o   = instr_i[10:6];
  assign dst_idx   = dst_sel_rd ? instr_i[15:11] : instr_i[20:16];
  assign imm_ext   = zext ? {{EXTW{1'b0}}, imm} : {{EXTW{imm[IMMW-1]}}, imm};

  always_comb begin
    alu_op      = A_ADD;
    reg_we      = 1'b0;
    dst_sel_rd  = 1'b0;
    alu_src_imm = 1'b0;
    mem_rd      = 1'b0;
    mem_wr      = 1'b0;
    br_eq       = 1'b0;
    br_ne       = 1'b0;
    jmp         = 1'b0;
    jmp_reg     = 1'b0;
    zext        = 1'b0;
    illegal     = 1'b0;
    case (opc)
      OP_REG: begin
        reg_we     = 1'b1;
        dst_sel_rd = 1'b1;
        case (fn)
          FN_ADD:  alu_op = A_ADD;
          FN_SUB:  alu_op = A_SUB;
          FN_AND:  alu_op = A_AND;
          FN_OR:   alu_op = A_OR;
          FN_XOR:  alu_op = A_XOR;
          FN_NOR:  alu_op = A_NOR;
          FN_SLT:  alu_op = A_SLT;
          FN_SLTU: alu_op = A_SLTU;
          FN_SLL:  alu_op = A_SLL;
          FN_SRL:  alu_op = A_SRL;
          FN_JR: begin
            reg_we     = 1'b0;
            dst_sel_rd = 1'b0;
            jmp_reg    = 1'b1;
          end
          default: begin
            reg_we     = 1'b0;
            dst_sel_rd = 1'b0;
            illegal    = 1'b1;
          end
        endcase
      end
      OP_ADDI:  begin reg_we = 1'b1; alu_src_imm = 1'b1; alu_op = A_ADD; end
      OP_SLTI:  begin reg_we = 1'b1; alu_src_imm = 1'b1; alu_op = A_SLT; end
      OP_SLTIU: begin reg_we = 1'b1; alu_src_imm = 1'b1; alu_op = A_SLTU; end
      OP_ANDI:  begin reg_we = 1'b1; alu_src_imm = 1'b1; alu_op = A_AND; zext = 1'b1; end
      OP_ORI:   begin reg_we = 1'b1; alu_src_imm = 1'b1; alu_op = A_OR;  zext = 1'b1; end
      OP_LW:    begin reg_we = 1'b1; alu_src_imm = 1'b1; mem_rd = 1'b1; end
      OP_SW:    begin alu_src_imm = 1'b1; mem_wr = 1'b1; end
      OP_BEQ:   begin alu_op = A_SUB; br_eq = 1'b1; end
      OP_BNE:   begin alu_op = A_SUB; br_ne = 1'b1; end
      OP_J:     jmp = 1'b1;
      default:  illegal = 1'b1;
    endcase
  end

  always_comb begin
    // R11
    flow_onehot_chk: assert ($onehot0({mem_rd, mem_wr, br_eq, br_ne, jmp, jmp_reg}));
    // R10
    illegal_quiet_chk: assert (!illegal || !(reg_we || mem_wr || mem_rd || jmp || jmp_reg || br_eq || br_ne));
    // R7
    store_nowrite_chk: assert (!mem_wr || (!reg_we && alu_src_imm));
    // R2
    rd_dest_chk: assert (!dst_sel_rd || (reg_we && !alu_src_imm && dst_idx == instr_i[15:11]));
    // R8
    branch_reg_chk: assert (!(br_eq || br_ne) || (!reg_we && !alu_src_imm && alu_op == A_SUB));
    // R5
    zext_upper_chk: assert (!(opc == OP_ANDI || opc == OP_ORI) || imm_ext[XLEN-1:IMMW] == '0);
  end

endmodule

// File: tb/test_instr_ctrl_decode.sv
module test_instr_ctrl_decode;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int N_RANDOM = 4000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0]     instr;
  logic [4:0]      src_a_idx, src_b_idx, dst_idx, shamt_o;
  logic [XLEN-1:0] imm_ext;
  logic [3:0]      alu_op;
  logic reg_we, dst_sel_rd, alu_src_imm, mem_rd, mem_wr, br_eq, br_ne, jmp, jmp_reg, illegal;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  instr_ctrl_decode #(.XLEN(XLEN)) i_instr_ctrl_decode (
    .instr_i(instr), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
    .shamt_o(shamt_o), .imm_ext(imm_ext), .alu_op(alu_op), .reg_we(reg_we),
    .dst_sel_rd(dst_sel_rd), .alu_src_imm(alu_src_imm), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .br_eq(br_eq), .br_ne(br_ne), .jmp(jmp), .jmp_reg(jmp_reg), .illegal(illegal)
  );

  // control vector: {alu_op, reg_we, dst_sel_rd, alu_src_imm, mem_rd, mem_wr, br_eq, br_ne, jmp, jmp_reg, illegal}
  function automatic logic [13:0] exp_ctl(input logic [31:0] w);
    logic [5:0] o, f;
    o = w[31:26];
    f = w[5:0];
    if (o == 6'b000000) begin
      if      (f == 6'b100000) return {4'd0, 10'b1100000000};
      else if (f == 6'b100010) return {4'd1, 10'b1100000000};
      else if (f == 6'b100100) return {4'd2, 10'b1100000000};
      else if (f == 6'b100101) return {4'd3, 10'b1100000000};
      else if (f == 6'b100110) return {4'd4, 10'b1100000000};
      else if (f == 6'b100111) return {4'd5, 10'b1100000000};
      else if (f == 6'b101010) return {4'd6, 10'b1100000000};
      else if (f == 6'b101011) return {4'd7, 10'b1100000000};
      else if (f == 6'b000000) return {4'd8, 10'b1100000000};
      else if (f == 6'b000010) return {4'd9, 10'b1100000000};
      else if (f == 6'b001000) return {4'd0, 10'b0000000010};
      else                     return {4'd0, 10'b0000000001};
    end
    else if (o == 6'b001000) return {4'd0, 10'b1010000000};
    else if (o == 6'b001010) return {4'd6, 10'b1010000000};
    else if (o == 6'b001011) return {4'd7, 10'b1010000000};
    else if (o == 6'b001100) return {4'd2, 10'b1010000000};
    else if (o == 6'b001101) return {4'd3, 10'b1010000000};
    else if (o == 6'b100011) return {4'd0, 10'b1011000000};
    else if (o == 6'b101011) return {4'd0, 10'b0010100000};
    else if (o == 6'b000100) return {4'd1, 10'b0000010000};
    else if (o == 6'b000101) return {4'd1, 10'b0000001000};
    else if (o == 6'b000010) return {4'd0, 10'b0000000100};
    else                     return {4'd0, 10'b0000000001};
  endfunction

  function automatic string req_of(input logic [31:0] w);
    logic [13:0] c;
    logic [5:0] o;
    c = exp_ctl(w);
    o = w[31:26];
    if (c[0]) return "R10";
    if (o == 6'b000000) return (c[1] ? "R3" : "R2");
    if (o == 6'b001100 || o == 6'b001101) return "R5";
    if (o == 6'b100011) return "R6";
    if (o == 6'b101011) return "R7";
    if (o == 6'b000100 || o == 6'b000101) return "R8";
    if (o == 6'b000010) return "R9";
    return "R4";
  endfunction

  function automatic logic [XLEN-1:0] exp_imm(input logic [31:0] w);
    if (w[31:26] == 6'b001100 || w[31:26] == 6'b001101) return XLEN'(w[15:0]);
    return XLEN'(signed'(w[15:0]));
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp, input logic [31:0] w);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, w, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    logic [13:0] c;
    string r;
    @(negedge clk);
    instr = w;
    #(CLK_PERIOD/4);
    c = exp_ctl(w);
    r = req_of(w);
    chk("R1", "fields", {src_a_idx, src_b_idx, shamt_o}, {w[25:21], w[20:16], w[10:6]}, w);
    chk(r, "ctl", {alu_op, reg_we, dst_sel_rd, alu_src_imm, mem_rd, mem_wr, br_eq, br_ne, jmp, jmp_reg, illegal}, c, w);
    // R11
    chk("R11", "flow_onehot", $countones({mem_rd, mem_wr, br_eq, br_ne, jmp, jmp_reg}) <= 1, 1, w);
    if (!c[0] && c[13:10] != 0 || c[9]) chk(r, "dst", dst_idx, c[8] ? w[15:11] : w[20:16], w);
    if (c[7]) chk(r, "imm", imm_ext, exp_imm(w), w);
  endtask

  function automatic logic [5:0] pick_op(input int s);
    case (s)
      0: return 6'b000000;  1: return 6'b001000;  2: return 6'b001010;  3: return 6'b001011;
      4: return 6'b001100;  5: return 6'b001101;  6: return 6'b100011;  7: return 6'b101011;
      8: return 6'b000100;  9: return 6'b000101;  10: return 6'b000010; 11: return 6'b000000;
      default: return 6'($urandom);
    endcase
  endfunction

  function automatic logic [5:0] pick_fn(input int s);
    case (s)
      0: return 6'b100000; 1: return 6'b100010; 2: return 6'b100100; 3: return 6'b100101;
      4: return 6'b100110; 5: return 6'b100111; 6: return 6'b101010; 7: return 6'b101011;
      8: return 6'b000000; 9: return 6'b000010; 10: return 6'b001000;
      default: return 6'($urandom);
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    instr = 32'h0;
    #(CLK_PERIOD/4);
    // all-zero word decodes as a shift: R2
    chk("R2", "zero_word", {alu_op, reg_we, illegal}, {4'd8, 1'b1, 1'b0}, instr);
    apply(32'h0232_4020);               // add rd=8 rs=17 rt=18 : R2
    apply(32'h0232_4022);               // sub : R2
    apply(32'h0012_4940);               // sll shamt=5 : R1 R2
    apply(32'h03E0_0008);               // jr : R3
    apply(32'h2229_8000);               // addi imm=-32768 : R4
    apply(32'h2229_7FFF);               // addi max positive : R4
    apply(32'h3229_FFFF);               // andi zero-extended : R5
    apply(32'h3629_8001);               // ori zero-extended : R5
    apply(32'h8E48_FFFC);               // lw offset -4 : R6
    apply(32'hAE48_FFFC);               // sw offset -4 : R7
    apply(32'h1109_0019);               // beq : R8
    apply(32'h1509_FFFF);               // bne : R8
    apply(32'h0800_0019);               // j : R9
    apply(32'hFC00_0000);               // unknown opcode : R10
    apply(32'h0232_4021);               // unknown function : R10
    apply(32'h3C01_FFFF);               // unlisted immediate opcode : R10
    for (int k = 0; k < N_RANDOM; k++) begin
      logic [31:0] w;
      w = $urandom;
      w[31:26] = pick_op(int'($urandom % 16));
      if (w[31:26] == 6'b000000) w[5:0] = pick_fn(int'($urandom % 14));
      apply(w);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule